// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block is the interlock control for a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Writeback) that has no operand bypass. Every instruction slot travels through the pipeline with a valid flag, an identifying tag, two source register ids, a destination register id and a register-write enable. While an instruction sits in Decode, its source ids are compared with the destination ids of the instructions in Compute, Memory and Writeback. If any of those will still write a register that Decode wants to read, the block stalls. It stops the program counter and keeps the Fetch/Decode buffer as it is. The instructions further down keep moving, and an empty slot is loaded into Compute in their place.

A dependent instruction therefore waits in Decode until its producer has finished Writeback. The wait is three cycles when the producer is the instruction just before it, two cycles when one instruction lies between them, one cycle for a gap of two, and none beyond that. Register data, the ALU and memory are not modelled. Writeback only presents a write strobe and the destination id. The fetch side is driven from outside: each cycle the environment supplies the instruction at the address on `pc`, and that instruction is captured when `pc_we` is high.

Top module: `hz_pipe`

## Requirements
- R1: While `rst` is high (synchronous, active high), all four stage slots are empty, `pc` is 0, `stall` is 0 and `pc_we` is 1. The state after reset is the same.
- R2: With no dependencies, one instruction enters Decode every cycle. Each instruction moves Decode→Compute→Memory→Writeback one stage per cycle, so N instructions finish Writeback in cycle N+3, counting cycle 0 as the first cycle after reset.
- R3: A read-after-write match on either source id against the destination of an instruction in Compute, Memory or Writeback stalls Decode. For a producer k instructions earlier (k = 1, 2, 3), the consumer waits 4−k bubble cycles. For k ≥ 4 it does not wait.
- R4: In a stall cycle, `pc_we` is 0, `pc` keeps its value and the Decode slot (valid and tag) is held. In every other cycle `pc_we` is 1 and `pc` advances by one.
- R5: Each stall cycle loads an empty (invalid, write-disabled) slot into Compute.
- R6: Compute, Memory and Writeback always advance. A slot in Compute is in Memory the next cycle and in Writeback the cycle after, whether or not Decode is stalled.
- R7: A destination id of 0 never causes a stall, even with the write enable set.
- R8: An instruction whose register-write enable is 0 never causes a stall.
- R9: `wb_we` is 1 exactly when Writeback holds a valid instruction with write enable set, and `wb_dst` then gives its destination id. Bubbles never write.
- R10: A consumer adjacent to its producer reaches Compute exactly two cycles after the producer's Writeback cycle, so its last Decode cycle is the one right after that Writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched instruction present at `pc` |
| in_tag | input | 8 | Identifying tag of the fetched instruction |
| in_src_a | input | 5 | First source register id |
| in_src_b | input | 5 | Second source register id |
| in_dst | input | 5 | Destination register id |
| in_wen | input | 1 | Register-write enable of the fetched instruction |
| pc | output | 8 | Fetch address |
| pc_we | output | 1 | Program counter update enable (low on stall) |
| stall | output | 1 | Decode hazard detected this cycle |
| d_valid | output | 1 | Decode slot occupied |
| d_tag | output | 8 | Decode slot tag |
| e_valid | output | 1 | Compute slot occupied |
| e_tag | output | 8 | Compute slot tag |
| m_valid | output | 1 | Memory slot occupied |
| m_tag | output | 8 | Memory slot tag |
| w_valid | output | 1 | Writeback slot occupied |
| w_tag | output | 8 | Writeback slot tag |
| wb_we | output | 1 | Register file write strobe |
| wb_dst | output | 5 | Register file write destination |

## Verification
The assertions assume that the fetch inputs are stable between clock edges and that the stall comes only from the three downstream producers. Under that assumption, no stall run lasts more than three cycles and the program counter never wraps in a run. The stimulus keeps to this. Traces are at most 16 instructions, so `pc` stays far below its limit. The inputs change only at the falling edge, based on the `pc` value sampled there. After each scenario the block is reset, so no dependency carries over from one trace to the next.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W       = 5;
    localparam int TAG_W       = 8;
    localparam int PC_W        = 8;
    localparam int LATE_STAGES = 3;   // Compute, Memory, Writeback
    localparam int RUN_W       = $clog2(LATE_STAGES + 2);

    typedef logic [REG_W-1:0] reg_id_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        reg_id_t          src_a;
        reg_id_t          src_b;
        reg_id_t          dst;
        logic             wen;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    // A slot that will update the register file (id 0 is never written).
    function automatic logic slot_writes(slot_t s);
        return s.valid && s.wen && (s.dst != '0);
    endfunction

    // A valid slot that names register r among its sources.
    function automatic logic slot_reads(slot_t s, reg_id_t r);
        return s.valid && ((s.src_a == r) || (s.src_b == r));
    endfunction
endpackage

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
(
    input  slot_t consumer,
    input  slot_t producer,
    output logic  hit
);
    always_comb begin
        hit = slot_writes(producer) && slot_reads(consumer, producer.dst);
    end
endmodule

// File: rtl/hz_stage.sv
module hz_stage
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= EMPTY_SLOT;
        else if (load) q <= d;
    end
endmodule

// File: rtl/hz_fetch.sv
module hz_fetch
    import hz_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  slot_t           fetched,
    output logic [PC_W-1:0] pc,
    output logic            pc_we,
    output slot_t           fd
);
    assign pc_we = !hold;

    always_ff @(posedge clk) begin
        if (rst)        pc <= '0;
        else if (pc_we) pc <= pc + 1'b1;
    end

    hz_stage u_fd (
        .clk  (clk),
        .rst  (rst),
        .load (pc_we),
        .d    (fetched),
        .q    (fd)
    );

    // R4: a stalled cycle leaves the fetch address alone
    a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> pc == $past(pc));

    // R4: a stalled cycle leaves the Fetch/Decode buffer alone
    a_r4_fd_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> fd == $past(fd));

    // R2: without a stall the fetch address steps by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !hold |=> pc == PC_W'($past(pc) + 1'b1));
endmodule

// File: rtl/hz_pipe.sv
module hz_pipe
    import hz_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [REG_W-1:0]      in_src_a,
    input  logic [REG_W-1:0]      in_src_b,
    input  logic [REG_W-1:0]      in_dst,
    input  logic                  in_wen,
    output logic [PC_W-1:0]       pc,
    output logic                  pc_we,
    output logic                  stall,
    output logic                  d_valid,
    output logic [TAG_W-1:0]      d_tag,
    output logic                  e_valid,
    output logic [TAG_W-1:0]      e_tag,
    output logic                  m_valid,
    output logic [TAG_W-1:0]      m_tag,
    output logic                  w_valid,
    output logic [TAG_W-1:0]      w_tag,
    output logic                  wb_we,
    output logic [REG_W-1:0]      wb_dst
);
    slot_t                  fetched;
    slot_t                  fd;
    slot_t                  late_in [LATE_STAGES];
    slot_t                  late_q  [LATE_STAGES];
    logic [LATE_STAGES-1:0] hits;

    assign fetched = '{valid: in_valid, tag: in_tag, src_a: in_src_a,
                       src_b: in_src_b, dst: in_dst, wen: in_wen};

    hz_fetch u_fetch (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .fetched (fetched),
        .pc      (pc),
        .pc_we   (pc_we),
        .fd      (fd)
    );

    // Downstream stages shift every cycle; the first takes a bubble on stall.
    for (genvar k = 0; k < LATE_STAGES; k++) begin : g_late
        if (k == 0) begin : g_head
            assign late_in[k] = stall ? EMPTY_SLOT : fd;
        end else begin : g_body
            assign late_in[k] = late_q[k-1];
        end

        hz_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .load (1'b1),
            .d    (late_in[k]),
            .q    (late_q[k])
        );

        hz_match u_match (
            .consumer (fd),
            .producer (late_q[k]),
            .hit      (hits[k])
        );
    end

    assign stall = |hits;

    assign d_valid = fd.valid;
    assign d_tag   = fd.tag;
    assign e_valid = late_q[0].valid;
    assign e_tag   = late_q[0].tag;
    assign m_valid = late_q[1].valid;
    assign m_tag   = late_q[1].tag;
    assign w_valid = late_q[LATE_STAGES-1].valid;
    assign w_tag   = late_q[LATE_STAGES-1].tag;
    assign wb_we   = slot_writes(late_q[LATE_STAGES-1]);
    assign wb_dst  = late_q[LATE_STAGES-1].dst;

    // Length of the current run of stall cycles (saturating), for checking only.
    logic [RUN_W-1:0] stall_run;
    always_ff @(posedge clk) begin
        if (rst)                                stall_run <= '0;
        else if (stall && (stall_run != '1))    stall_run <= stall_run + 1'b1;
        else if (!stall)                        stall_run <= '0;
    end

    // R3: a producer leaves the three late stages within three cycles
    a_r3_stall_bound: assert property (@(posedge clk) disable iff (rst)
        stall_run <= RUN_W'(LATE_STAGES));

    // R5: a stall cycle puts an empty slot into Compute
    a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
        stall |=> !late_q[0].valid && !late_q[0].wen);

    // R6: Compute moves into Memory regardless of stalls
    a_r6_adv_mem: assert property (@(posedge clk) disable iff (rst)
        late_q[0].valid |=> late_q[1] == $past(late_q[0]));

    // R6: Memory moves into Writeback regardless of stalls
    a_r6_adv_wb: assert property (@(posedge clk) disable iff (rst)
        late_q[1].valid |=> late_q[2] == $past(late_q[1]));
endmodule

// File: tb/hz_pipe_tb.sv
`timescale 1ns/1ps
module hz_pipe_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_tag = '0;
    logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       in_wen = 1'b0;
    logic [7:0] pc;
    logic       pc_we, stall;
    logic       d_valid, e_valid, m_valid, w_valid, wb_we;
    logic [7:0] d_tag, e_tag, m_tag, w_tag;
    logic [4:0] wb_dst;

    always #2 clk = ~clk;   // 250 MHz

    hz_pipe u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_wen(in_wen),
        .pc(pc), .pc_we(pc_we), .stall(stall),
        .d_valid(d_valid), .d_tag(d_tag), .e_valid(e_valid), .e_tag(e_tag),
        .m_valid(m_valid), .m_tag(m_tag), .w_valid(w_valid), .w_tag(w_tag),
        .wb_we(wb_we), .wb_dst(wb_dst)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int tr_sa[16], tr_sb[16], tr_dst[16], tr_wen[16];
    int ex_c[16];                 // reference Compute cycle of each instruction
    int obs_e[16], obs_w[16];     // observed Compute / Writeback cycles

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_ins(int i, int sa, int sb, int dst, int wen);
        tr_sa[i] = sa; tr_sb[i] = sb; tr_dst[i] = dst; tr_wen[i] = wen;
    endtask

    // Reference schedule: one per cycle, and a consumer enters Compute
    // no earlier than four cycles after any writing producer did.
    task automatic build_ref(int n);
        for (int i = 0; i < n; i++) begin
            ex_c[i] = (i == 0) ? 2 : ex_c[i-1] + 1;
            for (int j = 0; j < i; j++) begin
                if (tr_wen[j] != 0 && tr_dst[j] != 0 &&
                    (tr_dst[j] == tr_sa[i] || tr_dst[j] == tr_sb[i]) &&
                    ex_c[i] < ex_c[j] + 4)
                    ex_c[i] = ex_c[j] + 4;
            end
        end
    endtask

    task automatic drive_fetch(int n);
        int p;
        p = int'(pc);
        if (p < n) begin
            in_valid = 1'b1; in_tag = 8'(p);
            in_src_a = 5'(tr_sa[p]); in_src_b = 5'(tr_sb[p]);
            in_dst = 5'(tr_dst[p]); in_wen = tr_wen[p][0];
        end else begin
            in_valid = 1'b0; in_tag = '0; in_src_a = '0; in_src_b = '0;
            in_dst = '0; in_wen = 1'b0;
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int occ(logic v, logic [7:0] t);
        return v ? int'(t) : -1;
    endfunction

    function automatic int at_cycle(int n, int c);
        for (int i = 0; i < n; i++) if (ex_c[i] == c) return i;
        return -1;
    endfunction

    task automatic run(int n, string req);
        int last, bubbles_seen, done_c, exp_d, lo, exp_e, exp_w;
        build_ref(n);
        last = ex_c[n-1];
        bubbles_seen = 0; done_c = -1;
        for (int i = 0; i < 16; i++) begin obs_e[i] = -1; obs_w[i] = -1; end
        reset_dut();
        for (int c = 0; c <= last + 3; c++) begin
            exp_d = -1;
            for (int i = 0; i < n; i++) begin
                lo = (i == 0) ? 1 : ex_c[i-1];
                if (c >= lo && c < ex_c[i]) exp_d = i;
            end
            exp_e = at_cycle(n, c);
            exp_w = at_cycle(n, c - 2);
            chk("R4", "decode slot", occ(d_valid, d_tag), exp_d);
            chk("R5", "compute slot", occ(e_valid, e_tag), exp_e);
            chk("R6", "memory slot", occ(m_valid, m_tag), at_cycle(n, c - 1));
            chk("R6", "writeback slot", occ(w_valid, w_tag), exp_w);
            chk("R4", "pc_we", int'(pc_we),
                (c >= 2 && c + 1 <= last && at_cycle(n, c + 1) < 0) ? 0 : 1);
            chk("R9", "wb_we", int'(wb_we),
                (exp_w >= 0 && tr_wen[exp_w] != 0 && tr_dst[exp_w] != 0) ? 1 : 0);
            if (wb_we) chk("R9", "wb_dst", int'(wb_dst), tr_dst[exp_w]);
            if (!pc_we) bubbles_seen++;
            if (e_valid && int'(e_tag) < 16) obs_e[e_tag] = c;
            if (w_valid && int'(w_tag) < 16) obs_w[w_tag] = c;
            if (w_valid && int'(w_tag) == n - 1) done_c = c;
            drive_fetch(n);
            @(negedge clk);
        end
        chk(req, "stall cycles", bubbles_seen, last - 2 - (n - 1));
        chk(req, "finish cycle", done_c, last + 2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1; in_tag = 8'd9; in_src_a = 5'd1; in_dst = 5'd1; in_wen = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "pc", int'(pc), 0);
        chk("R1", "pc_we", int'(pc_we), 1);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "slots", int'({d_valid, e_valid, m_valid, w_valid}), 0);
        chk("R1", "wb_we", int'(wb_we), 0);
    endtask

    task automatic t_independent();   // R2: no waits, N instructions end at N+3
        for (int i = 0; i < 6; i++) set_ins(i, 20 + i, 26, i + 1, 1);
        run(6, "R2");
    endtask

    task automatic t_adjacent();      // R3 / R10: three bubbles
        set_ins(0, 10, 11, 3, 1);
        set_ins(1, 3, 12, 4, 1);
        set_ins(2, 13, 14, 5, 1);
        run(3, "R3");
        chk("R10", "consumer compute vs producer writeback", obs_e[1] - obs_w[0], 2);
    endtask

    task automatic t_distance();      // R3: gaps of 2, 3, 4 on the second source
        set_ins(0, 10, 11, 4, 1);
        set_ins(1, 12, 13, 6, 1);
        set_ins(2, 14, 4, 7, 1);      // gap 2 -> two bubbles
        set_ins(3, 15, 16, 8, 1);
        set_ins(4, 17, 18, 9, 1);
        set_ins(5, 8, 19, 2, 1);      // gap 2 from i3 after shift -> reference decides
        run(6, "R3");
        set_ins(0, 10, 11, 4, 1);
        set_ins(1, 12, 13, 6, 1);
        set_ins(2, 14, 15, 7, 1);
        set_ins(3, 16, 4, 8, 1);      // gap 3 -> one bubble
        set_ins(4, 17, 18, 9, 1);
        set_ins(5, 19, 20, 2, 1);
        set_ins(6, 21, 22, 5, 1);
        set_ins(7, 9, 23, 1, 1);      // gap 3 from i4 -> one bubble
        set_ins(8, 24, 25, 3, 1);
        set_ins(9, 26, 27, 30, 1);
        set_ins(10, 28, 29, 31, 1);
        set_ins(11, 3, 30, 0, 0);     // gap 3 from i8 plus gap 2 from i9
        run(12, "R3");
        set_ins(0, 10, 11, 4, 1);
        set_ins(1, 12, 13, 6, 1);
        set_ins(2, 14, 15, 7, 1);
        set_ins(3, 16, 17, 8, 1);
        set_ins(4, 4, 18, 9, 1);      // gap 4 -> no bubble
        run(5, "R3");
    endtask

    task automatic t_zero_dst();      // R7
        set_ins(0, 10, 11, 0, 1);
        set_ins(1, 0, 0, 5, 1);
        set_ins(2, 12, 0, 6, 1);
        run(3, "R7");
    endtask

    task automatic t_no_write();      // R8
        set_ins(0, 10, 11, 5, 0);
        set_ins(1, 5, 12, 6, 1);
        set_ins(2, 13, 5, 7, 1);
        run(3, "R8");
    endtask

    task automatic t_chain();         // R5 / R9: chained producers, mixed writes
        set_ins(0, 10, 11, 1, 1);
        set_ins(1, 1, 12, 2, 1);
        set_ins(2, 13, 2, 3, 1);
        set_ins(3, 14, 15, 16, 0);
        set_ins(4, 3, 16, 17, 1);
        run(5, "R5");
    endtask

    initial begin
        t_reset();
        t_independent();
        t_adjacent();
        t_distance();
        t_zero_dst();
        t_no_write();
        t_chain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule